// File: doc/BRIEF.md
# Status Flags and Branch Condition Unit

This block keeps the four condition flags of an 8-bit datapath (negative, zero, carry, overflow) and decides whether the instruction currently executing is a conditional branch and, if so, whether it is taken. Flags are derived from the ALU result together with the carry and overflow signals that the ALU supplies. They are captured on a rising clock edge, and only when the instruction asks for a flag update.

The branch decision is purely combinational. It reads the flags already held in the register, never the values about to be loaded. A branch opcode carries a fixed tag in its low five bits. Its top two bits choose one flag through a four-way multiplexer. Bit 5 gives the polarity the chosen flag must have for the branch to be taken.

Top module: `status_branch_unit`

## Requirements
- R1: While `rst_n` is low, the flag register is cleared to 0000 at once, without waiting for a clock edge. `flags_q` packs the flags as [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: On a load edge, N takes bit 7 of `alu_result`.
- R3: On a load edge, Z becomes 1 exactly when all eight bits of `alu_result` are zero.
- R4: On a load edge, C takes `alu_carry` and V takes `alu_ovf`. The two are independent of each other.
- R5: On any edge where `flag_we` is low, all four flags keep their value.
- R6: `is_branch` is high exactly when `opcode[4:0]` equals 5'b10000.
- R7: For a branch, `opcode[7:6]` chooses the tested flag (00=N, 01=Z, 10=C, 11=V). `branch_taken` is high when that flag equals `opcode[5]`.
- R8: `branch_taken` is low whenever `is_branch` is low.
- R9: A branch opcode never changes the flags, even when `flag_we` is high.
- R10: The branch decision uses the registered flags. A load on the same edge only affects decisions made after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| alu_result | input | 8 | Result of the current ALU operation |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU two's-complement overflow |
| flag_we | input | 1 | Current instruction updates the flags |
| opcode | input | 8 | Opcode of the instruction being executed |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |
| is_branch | output | 1 | Opcode matches the branch pattern |
| branch_taken | output | 1 | Branch condition satisfied |

## Verification
Two functions can fall in the same cycle: a flag load and a branch decision. One case is an ALU result presented with `flag_we` high while the opcode is itself a branch. The bench provokes this with branch opcodes carrying a live update enable and flag-changing ALU values. It judges the branch outcome against the flags held before the edge, and judges the register after the edge as unchanged. A second case pairs a near-miss opcode that loads flags with the following branch. Here the bench checks that the new flags only reach the decision one cycle later.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OPC_W   = 8;
  localparam int unsigned TAG_W   = 5;
  localparam int unsigned FLAGS_W = 4;
  localparam logic [TAG_W-1:0] BR_TAG = 5'b10000;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flags_t;

  typedef enum logic [1:0] {
    SEL_NEG   = 2'b00,
    SEL_ZERO  = 2'b01,
    SEL_CARRY = 2'b10,
    SEL_OVF   = 2'b11
  } flag_sel_e;
endpackage

// File: rtl/sbu_flag_gen.sv
module sbu_flag_gen
  import sbu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] result,
  input  logic         carry_in,
  input  logic         ovf_in,
  output flags_t       flags_d
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    flags_d.neg   = result[MSB];
    flags_d.zero  = ~(|result);
    flags_d.carry = carry_in;
    flags_d.ovf   = ovf_in;
  end
endmodule

// File: rtl/sbu_flag_reg.sv
module sbu_flag_reg
  import sbu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t flags_d,
  output flags_t flags_q
);
  flags_t flags_nxt;

  always_comb begin
    flags_nxt = flags_q;
    if (load) flags_nxt = flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(flags_q)); // R5
endmodule

// File: rtl/sbu_branch_dec.sv
module sbu_branch_dec
  import sbu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  flags_t           flags,
  output logic             is_branch,
  output logic             taken
);
  localparam int unsigned POL_BIT = TAG_W;

  flag_sel_e sel;
  logic      picked;

  always_comb begin
    is_branch = (opcode[TAG_W-1:0] == BR_TAG);
    sel       = flag_sel_e'(opcode[OPC_W-1:OPC_W-2]);
    unique case (sel)
      SEL_NEG:   picked = flags.neg;
      SEL_ZERO:  picked = flags.zero;
      SEL_CARRY: picked = flags.carry;
      SEL_OVF:   picked = flags.ovf;
      default:   picked = 1'b0;
    endcase
    taken = is_branch & (picked == opcode[POL_BIT]);
  end
endmodule

// File: rtl/status_branch_unit.sv
module status_branch_unit
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              flag_we,
  input  logic [OPC_W-1:0]  opcode,
  output logic [FLAGS_W-1:0] flags_q,
  output logic              is_branch,
  output logic              branch_taken
);
  flags_t flags_d;
  flags_t flags_r;
  logic   load;

  sbu_flag_gen #(.W(DATA_W)) u_gen (
    .result   (alu_result),
    .carry_in (alu_carry),
    .ovf_in   (alu_ovf),
    .flags_d  (flags_d)
  );

  assign load = flag_we & ~is_branch;

  sbu_flag_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .flags_d (flags_d),
    .flags_q (flags_r)
  );

  sbu_branch_dec u_dec (
    .opcode    (opcode),
    .flags     (flags_r),
    .is_branch (is_branch),
    .taken     (branch_taken)
  );

  assign flags_q = flags_r;

  AST_NEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && opcode[4:0] != 5'b10000) |=> flags_q[3] == $past(alu_result[DATA_W-1])); // R2
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && opcode[4:0] != 5'b10000) |=> flags_q[2] == ($past(alu_result) == '0)); // R3
  AST_CV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && opcode[4:0] != 5'b10000) |=> flags_q[1:0] == {$past(alu_carry), $past(alu_ovf)}); // R4
  AST_BRANCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode[4:0] == 5'b10000) |=> $stable(flags_q)); // R9
  AST_NO_BRANCH_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |-> !branch_taken); // R8
endmodule

// File: tb/sim_status_branch_unit.sv
module sim_status_branch_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] alu_result;
  logic       alu_carry, alu_ovf, flag_we;
  logic [7:0] opcode;
  logic [3:0] flags_q;
  logic       is_branch, branch_taken;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags;

  always #5 clk = ~clk;

  status_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .flag_we(flag_we), .opcode(opcode), .flags_q(flags_q),
    .is_branch(is_branch), .branch_taken(branch_taken)
  );

  // {opcode, alu_result, carry, ovf, we}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {8'h01, 8'h80, 1'b0, 1'b0, 1'b1},
    {8'h10, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h30, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h02, 8'h00, 1'b1, 1'b0, 1'b1},
    {8'h70, 8'h55, 1'b0, 1'b1, 1'b1},
    {8'hB0, 8'hFF, 1'b0, 1'b0, 1'b1},
    {8'h03, 8'h7F, 1'b0, 1'b1, 1'b1},
    {8'hD0, 8'h00, 1'b1, 1'b0, 1'b0},
    {8'hF0, 8'h80, 1'b1, 1'b1, 1'b1},
    {8'h31, 8'h01, 1'b0, 1'b0, 1'b1},
    {8'h50, 8'h00, 1'b1, 1'b1, 1'b1},
    {8'h90, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model of one cycle, from the requirements
  task automatic step(input logic [7:0] opc, input logic [7:0] res,
                      input logic c, input logic v, input logic we);
    logic isb, exp_t, sel_flag;
    opcode = opc; alu_result = res; alu_carry = c; alu_ovf = v; flag_we = we;
    #1;
    isb = (opc[4:0] == 5'b10000);
    sel_flag = mflags[3 - opc[7:6]];
    exp_t = isb && (sel_flag == opc[5]);
    chk("R6 is_branch", {7'd0, is_branch}, {7'd0, isb});
    chk("R7/R8/R10 branch_taken", {7'd0, branch_taken}, {7'd0, exp_t});
    @(posedge clk);
    if (we && !isb) mflags = {res[7], (res == 8'h00), c, v};
    @(negedge clk);
    chk("R2/R3/R4/R5/R9 flags", {4'd0, flags_q}, {4'd0, mflags});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = 8'h00; alu_result = 8'h00;
    alu_carry = 1'b0; alu_ovf = 1'b0; flag_we = 1'b0;
    mflags = 4'b0000;
    repeat (2) @(negedge clk);
    chk("R1 reset flags", {4'd0, flags_q}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      step(VEC[i][18:11], VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R2 and R3 corner: negative non-zero, then zero
    step(8'h00, 8'hFE, 1'b1, 1'b1, 1'b1);
    chk("R2 neg set", {7'd0, flags_q[3]}, 8'h01);
    step(8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R3 zero set", {7'd0, flags_q[2]}, 8'h01);
    // R5: update disabled with flag-changing result
    step(8'h04, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R5 hold", {4'd0, flags_q}, 8'h04);
    // R10: load with Z change, then branch on Z same cycle and next
    step(8'h05, 8'h01, 1'b0, 1'b0, 1'b1);
    opcode = 8'h70; flag_we = 1'b0; #1;
    chk("R10 decision after load", {7'd0, branch_taken}, 8'h00);
    // R9: branch with we high and result zero keeps flags
    step(8'h70, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R9 branch keeps flags", {4'd0, flags_q}, 8'h00);
    // R8: every non-branch encoding of the pattern's neighbours
    for (int k = 0; k < 32; k++) begin
      if (k[4:0] != 5'b10000) begin
        opcode = {3'b001, k[4:0]}; #1;
        chk("R8 not branch", {6'd0, is_branch, branch_taken}, 8'h00);
      end
    end
    // R1: asynchronous clear mid-cycle
    step(8'h00, 8'h80, 1'b1, 1'b1, 1'b1);
    #2 rst_n = 1'b0; #1;
    chk("R1 async clear", {4'd0, flags_q}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule